// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block records when an external event happens, measured against a free-running timer count that arrives from outside. The event comes either from a dedicated capture pin or from the output line of an on-chip comparator. A source-select bit picks between the two. The chosen line passes through a two-stage synchronizer. An optional glitch filter can follow it. An edge tracker then decides whether a transition is a qualifying event. On a qualifying event the present count is copied into a 16-bit capture register, and a capture flag rises in that same clock cycle. When interrupts are enabled, the flag drives an interrupt request.

Software reaches the block over an 8-bit register port with four addresses. Address 0 is the control register. Address 1 is the status register; writing one to bit 0 clears the flag. Address 2 returns the low capture byte. Address 3 returns the high capture byte. The 16-bit result is read low byte first. Reading the low byte also loads the upper half of the capture register into a one-byte hold latch, and the high-byte address returns that latch. The two bytes therefore always belong to the same capture, even if a new event arrives between the two reads. The interrupt controller can also clear the flag through an acknowledge input.

There are three small state machines. The filter FSM has the states FLT_STABLE and FLT_COUNT. It moves STABLE→COUNT when the input first differs from the held output. It moves COUNT→STABLE when the input returns to the held value, or when the fourth differing sample in a row arrives; in that second case the output toggles. The edge FSM has the states LVL_LOW and LVL_HIGH. It follows the conditioned line, and its LOW→HIGH or HIGH→LOW transition is the event, depending on the edge-select bit. The flag FSM has the states FLAG_CLEAR and FLAG_SET. It moves CLEAR→SET on an event. It moves SET→CLEAR on a clear request in a cycle with no event. It stays in SET on an event or when there is no clear.

Top module: `evstamp_unit`

## Requirements
- R1: After reset the control register, the status flag, the capture register and the hold latch read 0, and `irq_req` is 0.
- R2: With edge select = 1 (control bit 0), a 0→1 transition on the selected source loads the capture register with `count_val` and sets the flag in the same cycle. When the filter is off, this happens on the third rising clock edge after the input changes.
- R3: With edge select = 0, a 1→0 transition is the event. The transition opposite to the selected edge never sets the flag.
- R4: Control bit 1 selects the source: 0 selects `cap_pin` and 1 selects `cmp_out`. The line that is not selected never causes a capture.
- R5: With control bit 2 set, the filter changes its output only after four consecutive equal samples that differ from it. This adds four cycles of latency, and a pulse of three cycles or less causes no capture.
- R6: `irq_req` is high exactly when the flag is set and control bit 3 (interrupt enable) is 1.
- R7: A write to address 1 with data bit 0 = 1 clears the flag. A write with bit 0 = 0 leaves it unchanged.
- R8: A one-cycle `irq_ack` pulse clears the flag. An event in the same cycle as any clear request leaves the flag set.
- R9: A read of address 2 returns capture bits 7:0 and copies capture bits 15:8 into the hold latch. A read of address 3 returns the latch, even if a new capture has happened since the low read.
- R10: A new event overwrites the capture register while the flag is still set, and no overrun indication exists.
- R11: Address 0 reads back the four control bits in bits 3:0, with zeros above. Address 1 reads back the flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_val | input | 16 | Free-running timer count to be stamped |
| cap_pin | input | 1 | External capture pin, asynchronous |
| cmp_out | input | 1 | Comparator output line |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from addr |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |

## Verification
The checker watches every cycle for the following. An event must load the capture register with the count of that cycle and leave the flag set afterwards. The capture register and the hold latch must stay unchanged unless an event or a low-byte read occurs. The flag must drop after a write-one clear or an acknowledge, and must stay steady when there is neither a clear nor an event. The request must never be high without the flag. The bench scenarios are needed for the rest: the exact latency from the pin through the synchronizer and the filter, rejection of short pulses and of the unselected edge or source, overwrite without overrun, and a high-byte read that returns the old capture after a newer event.

// File: rtl/evstamp_pkg.sv
package evstamp_pkg;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_STAT  = 2'd1,
        REG_CAPLO = 2'd2,
        REG_CAPHI = 2'd3
    } reg_addr_e;

    // control bits, MSB first: bit3 irq_en, bit2 filt_en, bit1 src_cmp, bit0 rise_sel
    typedef struct packed {
        logic irq_en;
        logic filt_en;
        logic src_cmp;
        logic rise_sel;
    } ctrl_t;

    localparam int CTRL_BITS = 4;

    typedef enum logic {FLT_STABLE, FLT_COUNT} flt_state_e;
    typedef enum logic {LVL_LOW, LVL_HIGH}     lvl_state_e;
    typedef enum logic {FLAG_CLEAR, FLAG_SET}  flag_state_e;

endpackage

// File: rtl/evstamp_cond.sv
module evstamp_cond
    import evstamp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic cmp_raw,
    input  logic src_cmp,
    input  logic filt_en,
    output logic cond_o
);

    localparam int CW = $clog2(FILT_LEN) + 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic pin_s;
    logic cmp_s;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            logic pin_q, cmp_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pin_q <= 1'b0;
                    cmp_q <= 1'b0;
                end else begin
                    pin_q <= pin_raw;
                    cmp_q <= cmp_raw;
                end
            end
            assign pin_s = pin_q;
            assign cmp_s = cmp_q;
        end else begin : g_sync_chain
            logic [SYNC_STAGES-1:0] pin_sh, cmp_sh;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pin_sh <= '0;
                    cmp_sh <= '0;
                end else begin
                    pin_sh <= {pin_sh[SYNC_STAGES-2:0], pin_raw};
                    cmp_sh <= {cmp_sh[SYNC_STAGES-2:0], cmp_raw};
                end
            end
            assign pin_s = pin_sh[SYNC_STAGES-1];
            assign cmp_s = cmp_sh[SYNC_STAGES-1];
        end
    endgenerate

    logic sel_s;
    assign sel_s = src_cmp ? cmp_s : pin_s;

    flt_state_e      state_q, state_d;
    logic [CW-1:0]   run_q, run_d;
    logic            held_q, held_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FLT_STABLE;
            run_q   <= '0;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            held_q  <= held_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        held_d  = held_q;
        if (!filt_en) begin
            state_d = FLT_STABLE;
            run_d   = '0;
            held_d  = sel_s;
        end else begin
            unique case (state_q)
                FLT_STABLE: begin
                    if (sel_s != held_q) begin
                        state_d = FLT_COUNT;
                        run_d   = CW'(1);
                    end
                end
                FLT_COUNT: begin
                    if (sel_s == held_q) begin
                        state_d = FLT_STABLE;
                        run_d   = '0;
                    end else if (run_q == LAST) begin
                        state_d = FLT_STABLE;
                        run_d   = '0;
                        held_d  = sel_s;
                    end else begin
                        run_d = run_q + CW'(1);
                    end
                end
                default: state_d = FLT_STABLE;
            endcase
        end
    end

    // output
    always_comb begin
        cond_o = filt_en ? held_q : sel_s;
    end

endmodule

// File: rtl/evstamp_edge.sv
module evstamp_edge
    import evstamp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    input  logic rise_sel,
    output logic evt_o
);

    lvl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (cond_i)  state_d = LVL_HIGH;
            LVL_HIGH: if (!cond_i) state_d = LVL_LOW;
            default:  state_d = LVL_LOW;
        endcase
    end

    always_comb begin
        evt_o = 1'b0;
        unique case (state_q)
            LVL_LOW:  evt_o = cond_i && rise_sel;
            LVL_HIGH: evt_o = !cond_i && !rise_sel;
            default:  evt_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/evstamp_regs.sv
module evstamp_regs
    import evstamp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             evt_i,
    input  logic [1:0]       addr_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic             ack_i,
    output logic [BUS_W-1:0] rdata_o,
    output ctrl_t            ctrl_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic [CNT_W-1:0] cap_o,
    output logic [CNT_W-BUS_W-1:0] hold_o
);

    localparam int HI_W = CNT_W - BUS_W;

    reg_addr_e      addr;
    ctrl_t          ctrl_q;
    flag_state_e    flag_q, flag_d;
    logic [CNT_W-1:0] cap_q;
    logic [HI_W-1:0]  hold_q;
    logic             clr_req;

    assign addr    = reg_addr_e'(addr_i);
    assign clr_req = (wr_i && addr == REG_STAT && wdata_i[0]) || ack_i;

    // control, capture and hold registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cap_q  <= '0;
            hold_q <= '0;
        end else begin
            if (wr_i && addr == REG_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_BITS-1:0]);
            if (evt_i)                    cap_q  <= cnt_i;
            if (rd_i && addr == REG_CAPLO) hold_q <= cap_q[CNT_W-1:BUS_W];
        end
    end

    // flag state register
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= FLAG_CLEAR;
        else        flag_q <= flag_d;
    end

    // flag next state
    always_comb begin
        flag_d = flag_q;
        unique case (flag_q)
            FLAG_CLEAR: if (evt_i) flag_d = FLAG_SET;
            FLAG_SET:   if (!evt_i && clr_req) flag_d = FLAG_CLEAR;
            default:    flag_d = FLAG_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        flag_o = (flag_q == FLAG_SET);
        irq_o  = flag_o && ctrl_q.irq_en;
        ctrl_o = ctrl_q;
        cap_o  = cap_q;
        hold_o = hold_q;
        unique case (addr)
            REG_CTRL:  rdata_o = {{(BUS_W-CTRL_BITS){1'b0}}, ctrl_q};
            REG_STAT:  rdata_o = {{(BUS_W-1){1'b0}}, flag_o};
            REG_CAPLO: rdata_o = cap_q[BUS_W-1:0];
            REG_CAPHI: rdata_o = BUS_W'(hold_q);
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/evstamp_unit.sv
module evstamp_unit
    import evstamp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BUS_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_val,
    input  logic             cap_pin,
    input  logic             cmp_out,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq_req,
    input  logic             irq_ack
);

    localparam int HI_W = CNT_W - BUS_W;

    ctrl_t            ctrl;
    logic             cond_line;
    logic             capture_evt;
    logic             cap_flag;
    logic [CNT_W-1:0] cap_value;
    logic [HI_W-1:0]  hold_hi;

    evstamp_cond #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (cap_pin),
        .cmp_raw (cmp_out),
        .src_cmp (ctrl.src_cmp),
        .filt_en (ctrl.filt_en),
        .cond_o  (cond_line)
    );

    evstamp_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_i   (cond_line),
        .rise_sel (ctrl.rise_sel),
        .evt_o    (capture_evt)
    );

    evstamp_regs #(
        .CNT_W(CNT_W),
        .BUS_W(BUS_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (count_val),
        .evt_i   (capture_evt),
        .addr_i  (bus_addr),
        .wr_i    (bus_wr),
        .rd_i    (bus_rd),
        .wdata_i (bus_wdata),
        .ack_i   (irq_ack),
        .rdata_o (bus_rdata),
        .ctrl_o  (ctrl),
        .flag_o  (cap_flag),
        .irq_o   (irq_req),
        .cap_o   (cap_value),
        .hold_o  (hold_hi)
    );

endmodule

// File: rtl/evstamp_chk.sv
module evstamp_chk #(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_val,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [BUS_W-1:0] bus_wdata,
    input logic             irq_ack,
    input logic             irq_req,
    input logic             evt,
    input logic             flag,
    input logic [CNT_W-1:0] cap,
    input logic [CNT_W-BUS_W-1:0] hold
);

    logic w1c;
    assign w1c = bus_wr && bus_addr == 2'd1 && bus_wdata[0];

    // R2
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);

    // R10
    evt_loads_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> cap == $past(count_val));

    // R10
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(cap));

    // R6
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> flag);

    // R7
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && w1c) |=> !flag);

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && irq_ack) |=> !flag);

    // R7
    flag_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !irq_ack && !w1c) |=> $stable(flag));

    // R9
    hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == 2'd2) |=> $stable(hold));

endmodule

bind evstamp_unit evstamp_chk #(
    .CNT_W(CNT_W),
    .BUS_W(BUS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_val (count_val),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req),
    .evt       (capture_evt),
    .flag      (cap_flag),
    .cap       (cap_value),
    .hold      (hold_hi)
);

// File: tb/tb_evstamp_unit.sv
module tb_evstamp_unit;

    localparam logic [15:0] STEP = 16'h0111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = 16'h0;
    logic        cap_pin = 1'b0;
    logic        cmp_out = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h0;
    logic [7:0]  bus_rdata;
    logic        irq_req;
    logic        irq_ack = 1'b0;

    int total = 0;
    int fails = 0;
    logic [15:0] exp_q[$];
    logic [7:0]  lo_seen;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (!rst_n) cnt <= 16'h0;
        else        cnt <= cnt + STEP;
    end

    evstamp_unit dut (
        .clk(clk), .rst_n(rst_n), .count_val(cnt),
        .cap_pin(cap_pin), .cmp_out(cmp_out),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .irq_ack(irq_ack)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: assembles 16-bit reads and compares against the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_rd) begin
            if (bus_addr == 2'd2) lo_seen = bus_rdata;
            else if (bus_addr == 2'd3) begin
                if (exp_q.size() == 0)
                    check(1'b0, "R9 unexpected capture read", {bus_rdata, lo_seen}, 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check({bus_rdata, lo_seen} == e, "R2/R9/R10 capture value",
                          {bus_rdata, lo_seen}, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic read_lo();
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = 2'd2;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic read_hi();
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = 2'd3;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic expect_cap(input logic [15:0] v);
        exp_q.push_back(v);
        read_lo();
        read_hi();
    endtask

    task automatic drive(input bit use_cmp, input logic lvl, output logic [15:0] base);
        @(posedge clk); #1;
        if (use_cmp) cmp_out = lvl;
        else         cap_pin = lvl;
        base = cnt;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_pulse();
        @(posedge clk); #1;
        irq_ack = 1'b1;
        @(posedge clk); #1;
        irq_ack = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        total++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0]  rd;
        logic [15:0] b, b2, b3;

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(irq_req == 1'b0, "R1 irq after reset", irq_req, 0);
        bus_read(2'd0, rd); check(rd == 8'h00, "R1 ctrl after reset", rd, 0);
        bus_read(2'd1, rd); check(rd == 8'h00, "R1 flag after reset", rd, 0);
        expect_cap(16'h0000);

        // R11 control readback
        bus_write(2'd0, 8'h09);
        bus_read(2'd0, rd); check(rd == 8'h09, "R11 ctrl readback", rd, 8'h09);

        // R2 rising capture with exact latency, R6 interrupt
        drive(1'b0, 1'b1, b);
        idle(3); check(irq_req == 1'b0, "R2 no capture before third edge", irq_req, 0);
        idle(1); check(irq_req == 1'b1, "R2/R6 flag and irq on third edge", irq_req, 1);
        expect_cap(b + 16'd3 * STEP);

        // R7 write-zero no effect, write-one clears; R11 status bit
        bus_write(2'd1, 8'hFE);
        bus_read(2'd1, rd); check(rd == 8'h01, "R7 write 0 keeps flag", rd, 1);
        bus_write(2'd1, 8'h01);
        bus_read(2'd1, rd); check(rd == 8'h00, "R7 write 1 clears flag", rd, 0);
        check(irq_req == 1'b0, "R6 irq drops with flag", irq_req, 0);

        // R3 falling edge ignored under rising select
        drive(1'b0, 1'b0, b);
        idle(8); check(irq_req == 1'b0, "R3 falling ignored in rise mode", irq_req, 0);
        bus_write(2'd0, 8'h08);
        drive(1'b0, 1'b1, b);
        idle(8); check(irq_req == 1'b0, "R3 rising ignored in fall mode", irq_req, 0);
        drive(1'b0, 1'b0, b);
        idle(3); check(irq_req == 1'b0, "R3 fall not yet", irq_req, 0);
        idle(1); check(irq_req == 1'b1, "R3 falling capture", irq_req, 1);
        expect_cap(b + 16'd3 * STEP);

        // R8 acknowledge clears
        ack_pulse();
        @(negedge clk);
        check(irq_req == 1'b0, "R8 ack clears irq", irq_req, 0);
        bus_read(2'd1, rd); check(rd == 8'h00, "R8 ack clears flag", rd, 0);

        // R6 irq masked when enable bit is 0
        bus_write(2'd0, 8'h01);
        drive(1'b0, 1'b1, b);
        idle(8); check(irq_req == 1'b0, "R6 irq masked", irq_req, 0);
        bus_read(2'd1, rd); check(rd == 8'h01, "R6 flag set while masked", rd, 1);
        bus_write(2'd1, 8'h01);
        drive(1'b0, 1'b0, b);
        idle(8);

        // R4 comparator source, pin ignored
        bus_write(2'd0, 8'h0B);
        drive(1'b0, 1'b1, b);
        idle(8); check(irq_req == 1'b0, "R4 pin ignored with cmp source", irq_req, 0);
        drive(1'b0, 1'b0, b);
        idle(8);
        drive(1'b1, 1'b1, b);
        idle(3); check(irq_req == 1'b0, "R4 cmp not yet", irq_req, 0);
        idle(1); check(irq_req == 1'b1, "R4 cmp capture", irq_req, 1);
        expect_cap(b + 16'd3 * STEP);
        bus_write(2'd1, 8'h01);
        drive(1'b1, 1'b0, b);
        idle(8);

        // R5 filter: three-cycle pulse rejected, then four extra cycles of latency
        bus_write(2'd0, 8'h0D);
        idle(2);
        drive(1'b0, 1'b1, b);
        repeat (3) @(posedge clk);
        #1 cap_pin = 1'b0;
        idle(10); check(irq_req == 1'b0, "R5 short pulse rejected", irq_req, 0);
        drive(1'b0, 1'b1, b);
        idle(7); check(irq_req == 1'b0, "R5 filtered not yet", irq_req, 0);
        idle(1); check(irq_req == 1'b1, "R5 filtered capture", irq_req, 1);
        expect_cap(b + 16'd7 * STEP);
        bus_write(2'd1, 8'h01);
        drive(1'b0, 1'b0, b);
        idle(10);

        // R10 overwrite while flag set
        bus_write(2'd0, 8'h09);
        drive(1'b0, 1'b1, b);
        idle(8);
        drive(1'b0, 1'b0, b);
        idle(8);
        drive(1'b0, 1'b1, b2);
        idle(8);
        bus_read(2'd1, rd); check(rd == 8'h01, "R10 flag still set", rd, 1);
        expect_cap(b2 + 16'd3 * STEP);

        // R9 hold latch keeps the old high byte across a new capture
        exp_q.push_back(b2 + 16'd3 * STEP);
        read_lo();
        drive(1'b0, 1'b0, b);
        idle(8);
        drive(1'b0, 1'b1, b3);
        idle(8);
        read_hi();
        expect_cap(b3 + 16'd3 * STEP);

        check(exp_q.size() == 0, "R9 all expected reads seen", exp_q.size(), 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule